// File: doc/BRIEF.md
# PCI Type 0 Configuration Header Register File

This block holds the 64-byte Type 0 configuration header of a PCI function. It is a register file of sixteen 32-bit dwords. Configuration software reaches it through a dword index, a write strobe with four byte-lane enables and a read port. Reads are combinational on the index. A write takes effect at the clock edge that samples the strobe, so the new value can be read back in the next cycle.

Identity fields are fixed at elaboration: vendor and device IDs, revision, class code, subsystem IDs, capabilities pointer, interrupt pin, minimum grant and maximum latency. Software can write the Command register, the Latency Timer, the Interrupt Line and three Base Address Registers. Each BAR has a size from 16 bytes to 2 GB and a memory or I/O type, both fixed at elaboration. The Status register carries three error flags. Event inputs set these flags, and software clears them by writing one.

The target logic uses the decoded BAR bases and address masks, together with the command enables, to claim transactions. Every dword that is not implemented reads as zero and ignores writes.

Top module: `cfg_hdr_regs`

## Requirements
- R1: Dwords 0 ({device, vendor}), 2 ({class code, revision}), 11 ({subsystem ID, subsystem vendor ID}) and 13 (capabilities pointer in bits 7:0, rest zero) read their elaboration values, and writes to them have no effect.
- R2: Dwords 7, 8, 9, 10, 12 and 14 read as zero, and writes to them have no effect.
- R3: In dword 1, the Command half (bits 15:0) keeps only bits 0 (I/O enable), 1 (memory enable), 2 (bus master), 6 (parity response) and 8 (system error enable). These bits drive io_en_o, mem_en_o, bus_master_o, perr_resp_o and serr_en_o. All other Command bits read zero.
- R4: The Status error flags sit at dword 1 bit 31 (parity error, set by evt_perr_i), bit 30 (system error, set by evt_serr_i) and bit 27 (target abort, set by evt_tabort_i). Writing 1 to a flag with byte enable 3 set clears it. Writing 0 leaves it unchanged. If an event and a clear arrive in the same cycle, the flag stays set.
- R5: Dword 1 bit 20 (capability list) reads 1 when the capabilities pointer is nonzero. All other Status bits not named in R4 read zero.
- R6: In each BAR (dwords 4, 5, 6), the address bits below log2 of its size read zero. Writing all ones and reading back therefore shows the size.
- R7: A memory BAR reads bits 3:0 as 0. An I/O BAR reads bit 0 as 1 and bit 1 as 0.
- R8: bar_base_o slice n carries the programmed base of BAR n, and bar_mask_o slice n carries its address mask (ones on the decoded bits). The base changes only on a write to that BAR.
- R9: Each byte lane is written only when its enable bit is set. A write with all enables clear changes nothing.
- R10: Dword 3 bits 15:8 hold a writable Latency Timer. All other bits of dword 3 read zero.
- R11: Dword 15 reads {max latency, min grant, interrupt pin, interrupt line}. Only the interrupt line (bits 7:0) is writable.
- R12: After reset, Command, Status error flags, BARs, Latency Timer and Interrupt Line are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_idx_i | input | 4 | Dword index of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_be_i | input | 4 | Byte-lane enables for writes |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for acc_idx_i |
| evt_perr_i | input | 1 | Detected parity error event |
| evt_serr_i | input | 1 | Signalled system error event |
| evt_tabort_i | input | 1 | Signalled target abort event |
| io_en_o | output | 1 | I/O space decoding enabled |
| mem_en_o | output | 1 | Memory space decoding enabled |
| bus_master_o | output | 1 | Bus mastering enabled |
| perr_resp_o | output | 1 | Parity error response enabled |
| serr_en_o | output | 1 | System error reporting enabled |
| bar_base_o | output | 96 | Programmed BAR bases, BAR n in bits 32n+31:32n |
| bar_mask_o | output | 96 | BAR address masks, same slicing |

## Verification
The assertions check, on every cycle:
- that identity and unimplemented dwords read their fixed values;
- the BAR type bits and the capability flag;
- the set, clear and hold rules of the parity error flag;
- that the command enables and BAR bases stay stable whenever no write targets them.

Only the bench scenarios can show:
- the size discovery by an all-ones write;
- per-lane merging under partial byte enables;
- the set-over-clear priority when an event and a clear coincide;
- that random sequences of writes and events keep every readable field in step with a model built from the requirements.

// File: rtl/cfg_hdr_pkg.sv
`timescale 1ns/1ps
package cfg_hdr_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NUM_BARS = 3;
  localparam int unsigned NUM_ERR  = 3;

  localparam logic [IDX_W-1:0] IDX_ID     = 4'h0;
  localparam logic [IDX_W-1:0] IDX_CMDSTS = 4'h1;
  localparam logic [IDX_W-1:0] IDX_CLASS  = 4'h2;
  localparam logic [IDX_W-1:0] IDX_MISC   = 4'h3;
  localparam logic [IDX_W-1:0] IDX_BAR0   = 4'h4;
  localparam logic [IDX_W-1:0] IDX_SUBSYS = 4'hB;
  localparam logic [IDX_W-1:0] IDX_CAP    = 4'hD;
  localparam logic [IDX_W-1:0] IDX_INTR   = 4'hF;

  // writable command bits: io, mem, master, parity resp, serr
  localparam logic [15:0] CMD_WMASK = 16'h0147;
  localparam int unsigned CMD_IO    = 0;
  localparam int unsigned CMD_MEM   = 1;
  localparam int unsigned CMD_BM    = 2;
  localparam int unsigned CMD_PERR  = 6;
  localparam int unsigned CMD_SERR  = 8;

  localparam int unsigned STS_CAP = 4;
  // error flag positions in status half: perr, serr, target abort
  localparam int unsigned STS_ERR_POS [NUM_ERR] = '{15, 14, 11};

  function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] wdat,
                                             input logic [DW/8-1:0] be);
    logic [DW-1:0] r;
    for (int k = 0; k < DW/8; k++) r[8*k +: 8] = be[k] ? wdat[8*k +: 8] : cur[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfg_bar.sv
`timescale 1ns/1ps
module cfg_bar
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12,
  parameter bit          IS_IO     = 1'b0,
  parameter bit          ENABLE    = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [3:0]    be_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] rd_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] mask_o
);
  localparam logic [DW-1:0] ADDR_MASK = ENABLE ? ~((32'd1 << SIZE_LOG2) - 32'd1) : '0;
  localparam logic [DW-1:0] TYPE_BITS = (ENABLE && IS_IO) ? 32'd1 : 32'd0;

  logic [DW-1:0] bar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bar_q <= '0;
    else if (wr_i) bar_q <= be_merge(bar_q, data_i, be_i) & ADDR_MASK;
  end

  assign rd_o   = bar_q | TYPE_BITS;
  assign base_o = bar_q;
  assign mask_o = ADDR_MASK;
endmodule

// File: rtl/cfg_cmd_status.sv
`timescale 1ns/1ps
module cfg_cmd_status
  import cfg_hdr_pkg::*;
#(
  parameter bit CAP_PRESENT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [1:0]         cmd_be_i,
  input  logic [15:0]        cmd_data_i,
  input  logic [NUM_ERR-1:0] err_clr_i,
  input  logic [NUM_ERR-1:0] err_set_i,
  output logic [15:0]        cmd_o,
  output logic [15:0]        sts_o
);
  logic [15:0]        cmd_q;
  logic [DW-1:0]      cmd_m;
  logic [NUM_ERR-1:0] err_q;

  assign cmd_m = be_merge({16'h0, cmd_q}, {16'h0, cmd_data_i}, {2'b00, cmd_be_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_q <= '0;
    else if (cmd_wr_i) cmd_q <= cmd_m[15:0] & CMD_WMASK;
  end

  for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
    // event wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           err_q[e] <= 1'b0;
      else if (err_set_i[e]) err_q[e] <= 1'b1;
      else if (err_clr_i[e]) err_q[e] <= 1'b0;
    end
  end

  always_comb begin
    sts_o = '0;
    sts_o[STS_CAP] = CAP_PRESENT;
    for (int e = 0; e < NUM_ERR; e++) sts_o[STS_ERR_POS[e]] = err_q[e];
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/cfg_hdr_regs.sv
`timescale 1ns/1ps
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID  = 16'h0C41,
  parameter logic [7:0]  REV_ID     = 8'h03,
  parameter logic [23:0] CLASS_CODE = 24'h118000,
  parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
  parameter logic [15:0] SUBSYS_ID  = 16'h0007,
  parameter logic [7:0]  CAP_PTR    = 8'h40,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h02,
  parameter logic [7:0]  MAX_LAT    = 8'h08,
  // per BAR: log2 of size (4..31), I/O type, implemented
  parameter logic [NUM_BARS*5-1:0] BAR_LOG2 = {5'd31, 5'd4, 5'd12},
  parameter logic [NUM_BARS-1:0]   BAR_IO   = 3'b010,
  parameter logic [NUM_BARS-1:0]   BAR_EN   = 3'b111
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IDX_W-1:0]       acc_idx_i,
  input  logic                   wr_en_i,
  input  logic [3:0]             wr_be_i,
  input  logic [DW-1:0]          wr_data_i,
  output logic [DW-1:0]          rd_data_o,
  input  logic                   evt_perr_i,
  input  logic                   evt_serr_i,
  input  logic                   evt_tabort_i,
  output logic                   io_en_o,
  output logic                   mem_en_o,
  output logic                   bus_master_o,
  output logic                   perr_resp_o,
  output logic                   serr_en_o,
  output logic [NUM_BARS*DW-1:0] bar_base_o,
  output logic [NUM_BARS*DW-1:0] bar_mask_o
);
  logic [15:0]        cmd_w, sts_w;
  logic [NUM_ERR-1:0] err_clr, err_set;
  logic [DW-1:0]      bar_rd [NUM_BARS];
  logic [7:0]         lat_q, int_line_q;
  logic               cmd_wr;

  assign cmd_wr  = wr_en_i && (acc_idx_i == IDX_CMDSTS);
  assign err_set = {evt_tabort_i, evt_serr_i, evt_perr_i};

  always_comb begin
    for (int e = 0; e < NUM_ERR; e++)
      err_clr[e] = cmd_wr && wr_be_i[3] && wr_data_i[16 + STS_ERR_POS[e]];
  end

  cfg_cmd_status #(.CAP_PRESENT(CAP_PTR != 8'h00)) u_cmd_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr),
    .cmd_be_i   (wr_be_i[1:0]),
    .cmd_data_i (wr_data_i[15:0]),
    .err_clr_i  (err_clr),
    .err_set_i  (err_set),
    .cmd_o      (cmd_w),
    .sts_o      (sts_w)
  );

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    localparam logic [IDX_W-1:0] BIDX = IDX_BAR0 + 4'(g);
    cfg_bar #(
      .SIZE_LOG2 (int'(BAR_LOG2[g*5 +: 5])),
      .IS_IO     (BAR_IO[g]),
      .ENABLE    (BAR_EN[g])
    ) u_bar (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en_i && (acc_idx_i == BIDX)),
      .be_i   (wr_be_i),
      .data_i (wr_data_i),
      .rd_o   (bar_rd[g]),
      .base_o (bar_base_o[g*DW +: DW]),
      .mask_o (bar_mask_o[g*DW +: DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q      <= '0;
      int_line_q <= '0;
    end else if (wr_en_i) begin
      if (acc_idx_i == IDX_MISC && wr_be_i[1]) lat_q      <= wr_data_i[15:8];
      if (acc_idx_i == IDX_INTR && wr_be_i[0]) int_line_q <= wr_data_i[7:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (acc_idx_i)
      IDX_ID:     rd_data_o = {DEVICE_ID, VENDOR_ID};
      IDX_CMDSTS: rd_data_o = {sts_w, cmd_w};
      IDX_CLASS:  rd_data_o = {CLASS_CODE, REV_ID};
      IDX_MISC:   rd_data_o = {16'h0000, lat_q, 8'h00};
      IDX_SUBSYS: rd_data_o = {SUBSYS_ID, SUBSYS_VID};
      IDX_CAP:    rd_data_o = {24'h0, CAP_PTR};
      IDX_INTR:   rd_data_o = {MAX_LAT, MIN_GNT, INT_PIN, int_line_q};
      default:    rd_data_o = '0;
    endcase
    for (int b = 0; b < NUM_BARS; b++)
      if (acc_idx_i == IDX_BAR0 + 4'(b)) rd_data_o = bar_rd[b];
  end

  assign io_en_o      = cmd_w[CMD_IO];
  assign mem_en_o     = cmd_w[CMD_MEM];
  assign bus_master_o = cmd_w[CMD_BM];
  assign perr_resp_o  = cmd_w[CMD_PERR];
  assign serr_en_o    = cmd_w[CMD_SERR];
endmodule

// File: rtl/cfg_hdr_regs_chk.sv
`timescale 1ns/1ps
module cfg_hdr_regs_chk
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]         VENDOR_ID = 16'h1A2B,
  parameter logic [15:0]         DEVICE_ID = 16'h0C41,
  parameter logic [7:0]          CAP_PTR   = 8'h40,
  parameter logic [NUM_BARS-1:0] BAR_IO    = 3'b010,
  parameter logic [NUM_BARS-1:0] BAR_EN    = 3'b111
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [IDX_W-1:0]       acc_idx_i,
  input logic                   wr_en_i,
  input logic                   be3_i,
  input logic                   wbit31_i,
  input logic [DW-1:0]          rd_data_o,
  input logic                   evt_perr_i,
  input logic                   perr_flag_i,
  input logic                   io_en_o,
  input logic                   mem_en_o,
  input logic                   bus_master_o,
  input logic [NUM_BARS*DW-1:0] bar_base_o
);
  logic perr_clr;
  assign perr_clr = wr_en_i && acc_idx_i == IDX_CMDSTS && be3_i && wbit31_i;

  AST_ID_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_idx_i == IDX_ID |-> rd_data_o == {DEVICE_ID, VENDOR_ID}) else $error("id dword"); // R1

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_idx_i inside {4'd7, 4'd8, 4'd9, 4'd10, 4'd12, 4'd14} |-> rd_data_o == '0) else $error("unimpl"); // R2

  AST_CAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_idx_i == IDX_CMDSTS |-> rd_data_o[20] == (CAP_PTR != 8'h00)) else $error("cap flag"); // R5

  AST_PERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_perr_i |=> perr_flag_i) else $error("perr set"); // R4

  AST_PERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_clr && !evt_perr_i |=> !perr_flag_i) else $error("perr clr"); // R4

  AST_PERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_clr && !evt_perr_i |=> $stable(perr_flag_i)) else $error("perr hold"); // R4

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && acc_idx_i == IDX_CMDSTS) |=> $stable({io_en_o, mem_en_o, bus_master_o})) else $error("cmd hold"); // R3

  AST_BAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && acc_idx_i inside {4'd4, 4'd5, 4'd6}) |=> $stable(bar_base_o)) else $error("bar hold"); // R8

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bt
    localparam logic [IDX_W-1:0] BIDX = IDX_BAR0 + 4'(g);
    if (BAR_EN[g] && BAR_IO[g]) begin : g_io
      AST_BAR_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_idx_i == BIDX |-> rd_data_o[1:0] == 2'b01) else $error("io bar type"); // R7
    end else if (BAR_EN[g]) begin : g_mem
      AST_BAR_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_idx_i == BIDX |-> rd_data_o[3:0] == 4'h0) else $error("mem bar type"); // R7
    end
  end
endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(
  .VENDOR_ID (VENDOR_ID),
  .DEVICE_ID (DEVICE_ID),
  .CAP_PTR   (CAP_PTR),
  .BAR_IO    (BAR_IO),
  .BAR_EN    (BAR_EN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_idx_i    (acc_idx_i),
  .wr_en_i      (wr_en_i),
  .be3_i        (wr_be_i[3]),
  .wbit31_i     (wr_data_i[31]),
  .rd_data_o    (rd_data_o),
  .evt_perr_i   (evt_perr_i),
  .perr_flag_i  (sts_w[15]),
  .io_en_o      (io_en_o),
  .mem_en_o     (mem_en_o),
  .bus_master_o (bus_master_o),
  .bar_base_o   (bar_base_o)
);

// File: tb/cfg_hdr_regs_test.sv
`timescale 1ns/1ps
module cfg_hdr_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  acc_idx = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        evt_perr = 1'b0, evt_serr = 1'b0, evt_tabort = 1'b0;
  logic        io_en, mem_en, bus_master, perr_resp, serr_en;
  logic [95:0] bar_base, bar_mask;

  always #4 clk = ~clk;

  cfg_hdr_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_idx_i(acc_idx), .wr_en_i(wr_en), .wr_be_i(wr_be),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .evt_perr_i(evt_perr), .evt_serr_i(evt_serr),
    .evt_tabort_i(evt_tabort), .io_en_o(io_en), .mem_en_o(mem_en), .bus_master_o(bus_master),
    .perr_resp_o(perr_resp), .serr_en_o(serr_en), .bar_base_o(bar_base), .bar_mask_o(bar_mask)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model of writable state, built from the requirements
  logic [15:0] m_cmd = '0;
  logic [2:0]  m_err = '0;  // [0] parity, [1] system error, [2] target abort
  logic [7:0]  m_lat = '0, m_intl = '0;
  logic [31:0] m_bar [3] = '{32'h0, 32'h0, 32'h0};
  localparam logic [31:0] BMASK [3] = '{32'hFFFFF000, 32'hFFFFFFF0, 32'h80000000};

  function automatic logic [31:0] lane_mix(input logic [31:0] a, input logic [31:0] b,
                                           input logic [3:0] be);
    logic [31:0] r = a;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = b[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] i);
    logic [15:0] s = '0;
    case (i)
      4'd0:  return {16'h0C41, 16'h1A2B};
      4'd1: begin
        s[15] = m_err[0]; s[14] = m_err[1]; s[11] = m_err[2]; s[4] = 1'b1;
        return {s, m_cmd};
      end
      4'd2:  return {24'h118000, 8'h03};
      4'd3:  return {16'h0, m_lat, 8'h00};
      4'd4:  return m_bar[0];
      4'd5:  return m_bar[1] | 32'd1;
      4'd6:  return m_bar[2];
      4'd11: return {16'h0007, 16'h1A2B};
      4'd13: return 32'h40;
      4'd15: return {8'h08, 8'h02, 8'h01, m_intl};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic op(input logic [3:0] idx, input logic [3:0] be, input logic [31:0] data,
                    input logic wr, input logic [2:0] evt);
    logic [2:0]  clr = '0;
    logic [31:0] t;
    @(negedge clk);
    acc_idx = idx; wr_be = be; wr_data = data; wr_en = wr;
    {evt_tabort, evt_serr, evt_perr} = evt;
    @(posedge clk);
    if (wr) begin
      case (idx)
        4'd1: begin
          t = lane_mix({16'h0, m_cmd}, {16'h0, data[15:0]}, {2'b00, be[1:0]});
          m_cmd = t[15:0] & 16'h0147;
          if (be[3]) clr = {data[27], data[30], data[31]};
        end
        4'd3:  if (be[1]) m_lat = data[15:8];
        4'd4, 4'd5, 4'd6: begin
          int j = int'(idx) - 4;
          m_bar[j] = lane_mix(m_bar[j], data, be) & BMASK[j];
        end
        4'd15: if (be[0]) m_intl = data[7:0];
        default: ;
      endcase
    end
    m_err = (m_err & ~clr) | evt;
    @(negedge clk);
    wr_en = 1'b0; {evt_tabort, evt_serr, evt_perr} = 3'b000;
  endtask

  task automatic rd(input logic [3:0] idx, input string tag);
    acc_idx = idx;
    #1;
    chk(tag, rd_data, exp_rd(idx));
  endtask

  task automatic outs(input string tag);
    chk({tag, " cmd outputs"}, {27'b0, serr_en, perr_resp, bus_master, mem_en, io_en},
        {27'b0, m_cmd[8], m_cmd[6], m_cmd[2], m_cmd[1], m_cmd[0]});
    for (int b = 0; b < 3; b++) chk({tag, " bar base"}, bar_base[b*32 +: 32], m_bar[b]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state, R1 identity, R2 zero dwords
    for (int i = 0; i < 16; i++) rd(4'(i), "R12 reset read");
    outs("R12 reset");
    rd(4'd0, "R1 ids"); rd(4'd2, "R1 class"); rd(4'd11, "R1 subsys"); rd(4'd13, "R1 cap");
    rd(4'd1, "R5 cap flag");

    // R6/R7/R8 size discovery
    for (int b = 0; b < 3; b++) op(4'(4 + b), 4'hF, 32'hFFFFFFFF, 1'b1, 3'b000);
    acc_idx = 4'd4; #1; chk("R6 bar0 size", rd_data, 32'hFFFFF000);
    acc_idx = 4'd5; #1; chk("R7 io bar type", rd_data, 32'hFFFFFFF1);
    acc_idx = 4'd6; #1; chk("R6 bar2 2GB", rd_data, 32'h80000000);
    chk("R8 bar0 mask", bar_mask[31:0], 32'hFFFFF000);
    chk("R8 bar1 mask", bar_mask[63:32], 32'hFFFFFFF0);
    chk("R8 bar2 mask", bar_mask[95:64], 32'h80000000);
    outs("R8 after sizing");

    // R9 lane enables
    op(4'd4, 4'b0101, 32'h12345678, 1'b1, 3'b000);
    rd(4'd4, "R9 partial lanes");
    acc_idx = 4'd4; #1; chk("R9 partial lanes value", rd_data, 32'hFF34F000);
    op(4'd4, 4'b0000, 32'h0, 1'b1, 3'b000);
    rd(4'd4, "R9 no lanes");

    // R3 command
    op(4'd1, 4'b0011, 32'hFFFFFFFF, 1'b1, 3'b000);
    acc_idx = 4'd1; #1; chk("R3 cmd mask", rd_data[15:0], 16'h0147);
    outs("R3 cmd set");
    op(4'd1, 4'b0001, 32'h0, 1'b1, 3'b000);
    rd(4'd1, "R3 low lane only");
    outs("R3 low lane only");

    // R4 status flags
    op(4'd0, 4'h0, 32'h0, 1'b0, 3'b111);
    rd(4'd1, "R4 set by events");
    op(4'd1, 4'b1000, 32'h0, 1'b1, 3'b000);
    rd(4'd1, "R4 write zero keeps");
    op(4'd1, 4'b0111, 32'hFFFFFFFF, 1'b1, 3'b000);
    rd(4'd1, "R4 be3 off keeps");
    op(4'd1, 4'b1000, 32'h80000000, 1'b1, 3'b001);
    rd(4'd1, "R4 set beats clear");
    acc_idx = 4'd1; #1; chk("R4 set beats clear bit", {31'b0, rd_data[31]}, 32'd1);
    op(4'd1, 4'b1000, 32'h48000000, 1'b1, 3'b000);
    rd(4'd1, "R4 clear serr tabort");

    // R10, R11, R1, R2 write effects
    op(4'd3, 4'hF, 32'hA5C3E1F7, 1'b1, 3'b000);
    rd(4'd3, "R10 latency timer");
    op(4'd15, 4'hF, 32'h11223344, 1'b1, 3'b000);
    rd(4'd15, "R11 interrupt line");
    op(4'd0, 4'hF, 32'hDEADBEEF, 1'b1, 3'b000);
    rd(4'd0, "R1 write ignored");
    op(4'd7, 4'hF, 32'hFFFFFFFF, 1'b1, 3'b000);
    rd(4'd7, "R2 write ignored");
    op(4'd14, 4'hF, 32'hFFFFFFFF, 1'b1, 3'b000);
    rd(4'd14, "R2 write ignored 38h");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  idx = 4'($urandom_range(0, 15));
      logic [31:0] d   = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF : $urandom;
      logic [2:0]  ev;
      for (int e = 0; e < 3; e++) ev[e] = ($urandom_range(0, 7) == 0);
      op(idx, 4'($urandom), d, ($urandom_range(0, 9) < 7), ev);
      rd(4'($urandom_range(0, 15)), "R9 random read");
      rd(4'd1, "R4 random status");
      if (n % 20 == 0) outs("R8 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule